// File: doc/BRIEF.md
# Low-Power Sleep and Wake Sequencer

This block sits beside a small keyboard-controller core and controls its two sleep depths. A decoded halt strobe puts the core into a light sleep: the ALU clock enable drops, but the timer and interrupt logic stay clocked and the oscillator keeps running. A decoded stop strobe puts it into a deep sleep: the oscillator enable drops, so the whole core is unclocked. The block itself runs from a free-running reference clock, so it can still see wake events while the core is asleep.

Two events wake the core: a core reset request, or the host writing a byte into the input data buffer. On a host-write wake, the block reports whether the core should call the buffer-full interrupt handler or go on with the next instruction. This depends on whether that interrupt is enabled. A reset wake always reports a restart from program address zero, and reset wins over a host write in the same cycle.

Leaving deep sleep first turns the oscillator back on and runs a programmable stabilisation count. The clock enables return only when that count has expired.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: In run state (`state_o`=0), a halt strobe with no stop strobe and no core reset moves the block to light sleep (`state_o`=1) at the next clock. In light sleep `alu_clk_en_o`=0, `tmr_clk_en_o`=1 and `osc_en_o`=1.
- R2: In run state, a stop strobe with no core reset moves the block to deep sleep (`state_o`=2), with all three enables at 0. Stop wins over a simultaneous halt.
- R3: While `core_rst_i` is high in run state, halt and stop strobes are ignored and the block stays in run state.
- R4: In light sleep, a host write without core reset returns the block to run state at the next clock. It raises `resume_vld_o` with `resume_act_o`=2 (call the interrupt handler) if `ibf_ie_i`=1, or 3 (next instruction) if `ibf_ie_i`=0.
- R5: In light sleep, `core_rst_i` returns the block to run state at the next clock with `resume_act_o`=1 (restart from address zero).
- R6: A core reset and a host write in the same cycle resolve as a reset wake (action 1), in both sleep depths.
- R7: In deep sleep, a wake event moves the block to the stabilising state (`state_o`=3) with `osc_en_o`=1 and the ALU and timer enables at 0. `stab_cycles_i` is sampled at that clock. The block stays in the stabilising state for exactly `stab_cycles_i`+1 cycles, then enters run state with all enables at 1.
- R8: The resume action is fixed when the block wakes from deep sleep and is reported on entry to run state. A host write during stabilisation is ignored. A core reset during stabilisation changes the reported action to 1.
- R9: In run state, a host write or a core reset with no halt or stop changes neither the state nor the enables, and raises no resume pulse.
- R10: `resume_vld_o` is high for exactly one cycle, the first run-state cycle after a wake. `resume_act_o` is 0 whenever `resume_vld_o` is low.
- R11: After `rst_n` is released, the block is in run state with all enables at 1 and `resume_vld_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset of this block |
| halt_i | input | 1 | Decoded halt instruction strobe |
| stop_i | input | 1 | Decoded stop instruction strobe |
| core_rst_i | input | 1 | Core reset request, also a wake source |
| host_wr_i | input | 1 | Host write into the input data buffer |
| ibf_ie_i | input | 1 | Input-buffer-full interrupt enable |
| stab_cycles_i | input | CNT_W | Oscillator stabilisation count |
| alu_clk_en_o | output | 1 | ALU clock enable |
| tmr_clk_en_o | output | 1 | Timer and interrupt logic clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| resume_vld_o | output | 1 | One-cycle pulse when the core resumes |
| resume_act_o | output | 2 | Resume action: 0 none, 1 restart, 2 interrupt call, 3 next instruction |
| state_o | output | 2 | 0 run, 1 light sleep, 2 deep sleep, 3 stabilising |

## Verification
Directed sequences put the block into each sleep depth. Each depth is then woken by a host write with the interrupt enabled, a host write with it disabled, a lone reset, and a reset together with a host write. This separates the three resume actions and shows that reset wins. Stabilisation counts of 0, 5 and larger values check that the stabilising window is exactly one cycle longer than the count. Reset and host-write pulses during that window check that the action pending at the time is kept or changed to restart. Wake events sent in run state, and sleep strobes sent together with reset, show that neither changes any output. A long stretch of random strobes then mixes all of these orderings, and every output is compared each cycle against the behavioural model.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   typedef enum logic [1:0] {
      PS_RUN  = 2'd0,
      PS_SOFT = 2'd1,
      PS_HARD = 2'd2,
      PS_STAB = 2'd3
   } pstate_e;

   typedef enum logic [1:0] {
      RA_NONE    = 2'd0,
      RA_RESTART = 2'd1,
      RA_VECTOR  = 2'd2,
      RA_NEXT    = 2'd3
   } resume_e;
endpackage

// File: rtl/lpm_wake_sel.sv
module lpm_wake_sel
   import lpm_pkg::*;
(
   input  logic    core_rst_i,
   input  logic    host_wr_i,
   input  logic    ibf_ie_i,
   output logic    wake_o,
   output resume_e act_o
);
   // Reset outranks a host write (R6)
   always_comb begin
      wake_o = core_rst_i | host_wr_i;
      if (core_rst_i)
         act_o = RA_RESTART;
      else if (host_wr_i)
         act_o = ibf_ie_i ? RA_VECTOR : RA_NEXT;
      else
         act_o = RA_NONE;
   end
endmodule

// File: rtl/lpm_stab_timer.sv
module lpm_stab_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             run_i,
   output logic             done_o
);
   initial begin : p_chk
      assert (CNT_W >= 1 && CNT_W <= 32)
         else $error("lpm_stab_timer: CNT_W out of range");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= load_val_i;
      else if (run_i && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);

   // R7: a load of zero expires at once
   a_r7_zero_load: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && load_val_i == '0) |=> done_o);
endmodule

// File: rtl/lpm_clk_en.sv
module lpm_clk_en
   import lpm_pkg::*;
(
   input  pstate_e st_i,
   output logic    alu_en_o,
   output logic    tmr_en_o,
   output logic    osc_en_o
);
   always_comb begin
      unique case (st_i)
         PS_RUN:  begin alu_en_o = 1'b1; tmr_en_o = 1'b1; osc_en_o = 1'b1; end
         PS_SOFT: begin alu_en_o = 1'b0; tmr_en_o = 1'b1; osc_en_o = 1'b1; end
         PS_HARD: begin alu_en_o = 1'b0; tmr_en_o = 1'b0; osc_en_o = 1'b0; end
         default: begin alu_en_o = 1'b0; tmr_en_o = 1'b0; osc_en_o = 1'b1; end
      endcase
   end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
   import lpm_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    halt_i,
   input  logic    stop_i,
   input  logic    core_rst_i,
   input  logic    host_wr_i,
   input  logic    ibf_ie_i,
   input  logic    wake_i,
   input  resume_e wake_act_i,
   input  logic    done_i,
   output logic    load_o,
   output logic    run_timer_o,
   output pstate_e st_o,
   output logic    vld_o,
   output resume_e act_o
);
   pstate_e st_q, st_d;
   resume_e pend_q, pend_d;
   resume_e act_q, act_d;
   logic    vld_q, vld_d;

   always_comb begin
      st_d   = st_q;
      pend_d = pend_q;
      vld_d  = 1'b0;
      act_d  = RA_NONE;
      load_o = 1'b0;
      unique case (st_q)
         PS_RUN: begin
            if (!core_rst_i) begin
               if (stop_i)      st_d = PS_HARD;
               else if (halt_i) st_d = PS_SOFT;
            end
         end
         PS_SOFT: begin
            if (wake_i) begin
               st_d  = PS_RUN;
               vld_d = 1'b1;
               act_d = wake_act_i;
            end
         end
         PS_HARD: begin
            if (wake_i) begin
               st_d   = PS_STAB;
               pend_d = wake_act_i;
               load_o = 1'b1;
            end
         end
         default: begin
            if (core_rst_i) pend_d = RA_RESTART;
            if (done_i) begin
               st_d  = PS_RUN;
               vld_d = 1'b1;
               act_d = core_rst_i ? RA_RESTART : pend_q;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= PS_RUN;
         pend_q <= RA_NONE;
         vld_q  <= 1'b0;
         act_q  <= RA_NONE;
      end else begin
         st_q   <= st_d;
         pend_q <= pend_d;
         vld_q  <= vld_d;
         act_q  <= act_d;
      end
   end

   assign run_timer_o = (st_q == PS_STAB);
   assign st_o        = st_q;
   assign vld_o       = vld_q;
   assign act_o       = act_q;

   a_r1_halt_soft: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_RUN && halt_i && !stop_i && !core_rst_i) |=> st_q == PS_SOFT);
   a_r2_stop_hard: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_RUN && stop_i && !core_rst_i) |=> st_q == PS_HARD);
   a_r3_rst_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_RUN && core_rst_i) |=> st_q == PS_RUN);
   a_r4_host_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_SOFT && !core_rst_i && host_wr_i && ibf_ie_i) |=> (vld_q && act_q == RA_VECTOR));
   a_r5_rst_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_SOFT && core_rst_i) |=> (vld_q && act_q == RA_RESTART));
   a_r7_hold_stab: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_STAB && !done_i) |=> st_q == PS_STAB);
   a_r7_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_HARD) |=> st_q != PS_RUN);
   a_r9_idle_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_RUN && !halt_i && !stop_i) |=> (st_q == PS_RUN && !vld_q));
   a_r10_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |=> !vld_q);
   a_r10_act_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q != RA_NONE) |-> (vld_q && st_q == PS_RUN));
endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl
   import lpm_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             halt_i,
   input  logic             stop_i,
   input  logic             core_rst_i,
   input  logic             host_wr_i,
   input  logic             ibf_ie_i,
   input  logic [CNT_W-1:0] stab_cycles_i,
   output logic             alu_clk_en_o,
   output logic             tmr_clk_en_o,
   output logic             osc_en_o,
   output logic             resume_vld_o,
   output logic [1:0]       resume_act_o,
   output logic [1:0]       state_o
);
   logic    wake, load, run_tmr, done;
   resume_e wake_act, act;
   pstate_e st;

   lpm_wake_sel u_sel (
      .core_rst_i (core_rst_i),
      .host_wr_i  (host_wr_i),
      .ibf_ie_i   (ibf_ie_i),
      .wake_o     (wake),
      .act_o      (wake_act)
   );

   lpm_stab_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .load_val_i (stab_cycles_i),
      .run_i      (run_tmr),
      .done_o     (done)
   );

   lpm_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .halt_i      (halt_i),
      .stop_i      (stop_i),
      .core_rst_i  (core_rst_i),
      .host_wr_i   (host_wr_i),
      .ibf_ie_i    (ibf_ie_i),
      .wake_i      (wake),
      .wake_act_i  (wake_act),
      .done_i      (done),
      .load_o      (load),
      .run_timer_o (run_tmr),
      .st_o        (st),
      .vld_o       (resume_vld_o),
      .act_o       (act)
   );

   lpm_clk_en u_en (
      .st_i     (st),
      .alu_en_o (alu_clk_en_o),
      .tmr_en_o (tmr_clk_en_o),
      .osc_en_o (osc_en_o)
   );

   assign resume_act_o = act;
   assign state_o      = st;

   // R7: ALU clock only returns through a pulse-marked entry to run state
   a_r7_alu_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alu_clk_en_o) |-> resume_vld_o);
endmodule

// File: tb/lpm_wake_ctrl_test.sv
module lpm_wake_ctrl_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic halt = 0, stop = 0, crst = 0, hwr = 0, ie = 0;
   logic [7:0] stab = 8'd0;
   logic alu_en, tmr_en, osc_en, vld;
   logic [1:0] act, st;

   int total = 0, bad = 0, cyc = 0;
   bit finished = 0;
   string cur_req = "R11";

   // reference model state
   int m_st = 0, m_cnt = 0, m_pend = 0, m_act = 0;
   bit m_vld = 0;

   always #10 clk = ~clk;

   lpm_wake_ctrl #(.CNT_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .halt_i(halt), .stop_i(stop),
      .core_rst_i(crst), .host_wr_i(hwr), .ibf_ie_i(ie),
      .stab_cycles_i(stab), .alu_clk_en_o(alu_en), .tmr_clk_en_o(tmr_en),
      .osc_en_o(osc_en), .resume_vld_o(vld), .resume_act_o(act), .state_o(st)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_pend = 0; m_act = 0; m_vld = 0;
      end else begin
         m_vld = 0; m_act = 0;
         case (m_st)
            0: if (!crst) begin
                  if (stop) m_st = 2; else if (halt) m_st = 1;
               end
            1: if (crst) begin
                  m_st = 0; m_vld = 1; m_act = 1;
               end else if (hwr) begin
                  m_st = 0; m_vld = 1; m_act = ie ? 2 : 3;
               end
            2: if (crst || hwr) begin
                  m_st = 3; m_cnt = int'(stab);
                  m_pend = crst ? 1 : (ie ? 2 : 3);
               end
            default: begin
               if (crst) m_pend = 1;
               if (m_cnt == 0) begin
                  m_st = 0; m_vld = 1; m_act = m_pend;
               end else m_cnt = m_cnt - 1;
            end
         endcase
      end
   end

   task automatic finish_up();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(negedge clk) begin
      if (!finished) begin
         bit e_alu, e_tmr, e_osc;
         e_alu = (m_st == 0);
         e_tmr = (m_st == 0 || m_st == 1);
         e_osc = (m_st != 2);
         total++;
         if (alu_en !== e_alu || tmr_en !== e_tmr || osc_en !== e_osc ||
             vld !== m_vld || int'(act) != m_act || int'(st) != m_st) begin
            bad++;
            $display("FAIL %s: got st=%0d en=%b%b%b vld=%b act=%0d exp st=%0d en=%b%b%b vld=%b act=%0d",
                     cur_req, st, alu_en, tmr_en, osc_en, vld, act,
                     m_st, e_alu, e_tmr, e_osc, m_vld, m_act);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         bad++;
         $display("FAIL watchdog: got cycles=%0d exp below 150000", cyc);
         finish_up();
      end
   end

   task automatic drv(input bit h, input bit s, input bit r, input bit w,
                      input bit e, input int n = 1);
      repeat (n) begin
         @(negedge clk);
         halt = h; stop = s; crst = r; hwr = w; ie = e;
      end
   endtask

   task automatic idle(input int n);
      drv(0, 0, 0, 0, ie, n);
   endtask

   initial begin
      cur_req = "R11";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(3);

      cur_req = "R9";          // wake events in run state
      drv(0, 0, 0, 1, 1); drv(0, 0, 1, 0, 0); drv(0, 0, 1, 1, 1); idle(3);

      cur_req = "R3";          // sleep strobes under reset
      drv(1, 0, 1, 0, 0); drv(0, 1, 1, 0, 0); drv(1, 1, 1, 0, 0); idle(3);

      cur_req = "R1";
      drv(1, 0, 0, 0, 1); idle(4);
      cur_req = "R4";          // host write, interrupt on
      drv(0, 0, 0, 1, 1); idle(3);
      cur_req = "R4";          // host write, interrupt off
      drv(1, 0, 0, 0, 0); idle(2); drv(0, 0, 0, 1, 0); idle(3);

      cur_req = "R5";
      drv(1, 0, 0, 0, 0); idle(2); drv(0, 0, 1, 0, 1); idle(3);
      cur_req = "R6";
      drv(1, 0, 0, 0, 0); idle(2); drv(0, 0, 1, 1, 1); idle(3);

      cur_req = "R2";          // stop wins over halt
      drv(1, 1, 0, 0, 0); idle(4);
      cur_req = "R7";
      stab = 8'd5; drv(0, 0, 0, 1, 1); idle(10);
      cur_req = "R7";          // zero count
      drv(0, 1, 0, 0, 0); idle(2);
      stab = 8'd0; drv(0, 0, 0, 1, 0); idle(4);
      cur_req = "R6";
      drv(0, 1, 0, 0, 0); idle(2);
      stab = 8'd3; drv(0, 0, 1, 1, 1); idle(7);

      cur_req = "R8";          // host write during window ignored
      drv(0, 1, 0, 0, 0); idle(2);
      stab = 8'd6; drv(0, 0, 0, 1, 0); idle(2); drv(0, 0, 0, 1, 1); idle(8);
      cur_req = "R8";          // reset during window turns into restart
      drv(0, 1, 0, 0, 0); idle(2);
      stab = 8'd6; drv(0, 0, 0, 1, 1); idle(2); drv(0, 0, 1, 0, 1); idle(8);
      cur_req = "R8";          // reset on the expiring cycle
      drv(0, 1, 0, 0, 0); idle(2);
      stab = 8'd2; drv(0, 0, 0, 1, 1); idle(2); drv(0, 0, 1, 0, 1); idle(4);

      cur_req = "R10";         // random mix
      for (int i = 0; i < 4000; i++) begin
         stab = 8'($urandom_range(0, 12));
         drv($urandom_range(0, 7) == 0, $urandom_range(0, 11) == 0,
             $urandom_range(0, 15) == 0, $urandom_range(0, 9) == 0,
             $urandom_range(0, 1) == 1);
      end
      idle(20);
      finish_up();
   end
endmodule